// File: doc/BRIEF.md
# Delayed-Commit Value Register

This block holds one 32-bit signed value whose updates take effect only after a programmable delay. A write places the new value in a pending slot and loads a millisecond down-counter with the delay presented alongside the write. Until that counter has run out, the read port keeps showing the value that was committed before the write. On the clock edge after the count reaches zero, the pending value becomes the committed one and appears on the read port.

The block keeps exactly one timer, one latest-written value and one committed value. A second write while a delay is running replaces the pending value and starts the delay again from the newly supplied length. The committed value is not touched by that write. Time is counted in pulses of a one-cycle `ms_tick` input that an external divider supplies. A `pending` flag shows that a commit is outstanding.

A two-state controller drives the sequence. `ST_IDLE` means nothing is outstanding. The transition *write* moves it to `ST_WAIT`. In `ST_WAIT`, the transition *restart* (another write) stays in `ST_WAIT` and reloads the timer. The transition *expire* (count at zero, no write) returns it to `ST_IDLE` and commits the pending value.

Top module: `dcv_reg`

## Requirements
- R1: `rd_data` is a 32-bit two's-complement value, and any written pattern, including negative values and the extremes, is returned unchanged after its commit.
- R2: While `pending` is high, `rd_data` holds the value committed before the most recent write.
- R3: With delay d, the commit happens on the first clock edge at which d `ms_tick` pulses have been counted since the write edge. A tick that arrives in the same cycle as the write is not counted. After the commit, `rd_data` shows the latest written value.
- R4: `rd_data` changes only on a commit edge, and `pending` falls on that same edge.
- R5: A write while `pending` is high replaces the pending value and reloads the timer with the new delay. `rd_data` keeps its old value until the new delay has expired.
- R6: A write with delay 0 is committed on the next clock edge, so `rd_data` shows it one cycle after the write edge.
- R7: `pending` is high from the edge that takes a write until the commit edge, and low at all other times.
- R8: Reset (active-low `rst_n`) clears both stored values to 0, stops the timer and drives `pending` low.
- R9: `ms_tick` pulses while `pending` is low have no effect on `rd_data` or `pending`, and they do not shorten a later delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Signed value to write |
| delay_ms | input | 16 | Delay in milliseconds, sampled with the write |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| rd_data | output | 32 | Committed signed value |
| pending | output | 1 | A written value awaits commit |

## Verification
The hardest case to reach from the ports is a write that lands in the exact cycle where the count has just reached zero. In that cycle the *restart* transition must win over *expire*, and the old value must stay on the read port. The bench sets this up directly: it writes with a small delay, delivers exactly that many ticks, and then writes again on the following cycle. Random writes, delays and ticks, checked every cycle against a bench model, also cover overlapping writes and ticks that coincide with writes.

// File: rtl/dcv_pkg.sv
package dcv_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } dcv_state_e;
endpackage

// File: rtl/dcv_timer.sv
// Millisecond down-counter: loaded on a write, counts ticks down to zero.
module dcv_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             tick,
    output logic             zero
);
    logic [DLY_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (tick && (count_q != '0)) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign zero = (count_q == '0);
endmodule

// File: rtl/dcv_fsm.sv
// Two-state sequencer: write -> ST_WAIT, restart stays, expire commits.
module dcv_fsm
    import dcv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic zero,
    output logic load,
    output logic commit,
    output logic busy
);
    dcv_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_en) state_d = ST_WAIT;
            ST_WAIT: begin
                if (wr_en)     state_d = ST_WAIT;
                else if (zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load   = wr_en;
        commit = 1'b0;
        busy   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: begin
                busy   = 1'b1;
                commit = !wr_en && zero;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dcv_store.sv
// Latest-written copy and committed copy of the value.
module dcv_store #(
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic signed [DATA_W-1:0] wr_data,
    input  logic                     commit,
    output logic signed [DATA_W-1:0] committed
);
    logic signed [DATA_W-1:0] latest_q;
    logic signed [DATA_W-1:0] shown_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latest_q <= '0;
            shown_q  <= '0;
        end else begin
            if (wr_en)  latest_q <= wr_data;
            if (commit) shown_q  <= latest_q;
        end
    end

    assign committed = shown_q;
endmodule

// File: rtl/dcv_reg.sv
module dcv_reg #(
    parameter int DATA_W = 32,
    parameter int DLY_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic signed [DATA_W-1:0] wr_data,
    input  logic [DLY_W-1:0]         delay_ms,
    input  logic                     ms_tick,
    output logic signed [DATA_W-1:0] rd_data,
    output logic                     pending
);
    logic load, commit, busy, zero;

    dcv_timer #(.DLY_W(DLY_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(delay_ms),
        .tick(ms_tick), .zero(zero)
    );

    dcv_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .zero(zero),
        .load(load), .commit(commit), .busy(busy)
    );

    dcv_store #(.DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .commit(commit), .committed(rd_data)
    );

    assign pending = busy;
endmodule

// File: rtl/dcv_reg_chk.sv
module dcv_reg_chk #(
    parameter int DATA_W = 32,
    parameter int DLY_W  = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic signed [DATA_W-1:0] wr_data,
    input logic [DLY_W-1:0]         delay_ms,
    input logic                     ms_tick,
    input logic signed [DATA_W-1:0] rd_data,
    input logic                     pending
);
    p_hold_while_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> $stable(rd_data));

    p_change_at_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> ($past(pending) && !pending));

    p_zero_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && delay_ms == '0) ##1 !wr_en |=> (!pending && rd_data == $past(wr_data, 2)));

    p_pending_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pending);

    p_idle_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && !wr_en) |=> (!pending && $stable(rd_data)));
endmodule

bind dcv_reg dcv_reg_chk #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_chk (.*);

// File: tb/dcv_reg_test.sv
module dcv_reg_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic signed [31:0] wr_data = '0;
    logic [15:0]        delay_ms = '0;
    logic               ms_tick = 1'b0;
    logic signed [31:0] rd_data;
    logic               pending;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic signed [31:0] m_latest, m_shown;
    int                 m_cnt;
    bit                 m_busy;

    always #10 clk = ~clk;

    dcv_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .delay_ms(delay_ms), .ms_tick(ms_tick), .rd_data(rd_data), .pending(pending)
    );

    task automatic check(string req, logic signed [31:0] act, logic signed [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void model_edge(bit w, logic signed [31:0] d, int dl, bit t);
        if (w) begin
            m_latest = d;
            m_cnt    = dl;
            m_busy   = 1;
        end else if (m_busy) begin
            if (m_cnt == 0) begin
                m_shown = m_latest;
                m_busy  = 0;
            end else if (t) begin
                m_cnt--;
            end
        end
    endfunction

    // one cycle: drive at negedge, model at posedge, compare 2 ns later
    task automatic step(bit w, logic signed [31:0] d, int dl, bit t, string req);
        @(negedge clk);
        wr_en = w; wr_data = d; delay_ms = 16'(dl); ms_tick = t;
        @(posedge clk);
        model_edge(w, d, dl, t);
        #2;
        check({req, " rd_data"}, rd_data, m_shown);
        check({req, " pending"}, {31'd0, pending}, {31'd0, m_busy});
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_latest = '0; m_shown = '0; m_cnt = 0; m_busy = 0;
        repeat (3) @(posedge clk);
        #2;
        check("R8 reset rd_data", rd_data, 0);
        check("R8 reset pending", {31'd0, pending}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R9: idle ticks do nothing
        repeat (5) step(0, 0, 0, 1, "R9 idle tick");
        // R6: zero delay, R1 negative value
        step(1, -32'sd5, 0, 0, "R6 write d0");
        step(0, 0, 0, 0, "R6 commit");
        check("R6 value", rd_data, -32'sd5);
        // R3: delay 3, tick on write cycle ignored
        step(1, 32'sh7FFFFFFF, 3, 1, "R3 write tick ignored");
        repeat (3) step(0, 0, 0, 1, "R3 count");
        check("R2 held before expiry", rd_data, -32'sd5);
        step(0, 0, 0, 0, "R3 commit");
        check("R1 max value", rd_data, 32'sh7FFFFFFF);
        // R5: write on the cycle where count just reached zero
        step(1, 32'sh80000000, 2, 0, "R5 first write");
        repeat (2) step(0, 0, 0, 1, "R5 count");
        step(1, 32'sd77, 1, 0, "R5 restart at zero");
        check("R5 old value kept", rd_data, 32'sh7FFFFFFF);
        step(0, 0, 0, 1, "R5 tick");
        step(0, 0, 0, 0, "R5 commit");
        check("R5 new value", rd_data, 32'sd77);
        // R9: idle ticks do not shorten a later delay
        repeat (4) step(0, 0, 0, 1, "R9 idle ticks");
        step(1, 32'sd9, 2, 0, "R9 write");
        step(0, 0, 0, 0, "R9 no tick");
        check("R9 still pending", {31'd0, pending}, 1);

        // random mix: R1 R2 R3 R4 R5 R7
        for (int i = 0; i < 4000; i++) begin
            bit w = ($urandom_range(0, 11) == 0);
            bit t = ($urandom_range(0, 3) == 0);
            step(w, $signed($urandom()), $urandom_range(0, 5), t, "R4 R7 random");
        end

        // R8: reset mid-delay
        step(1, 32'sd3, 4, 0, "R8 pre");
        @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; ms_tick = 1'b0;
        @(posedge clk); #2;
        check("R8 mid reset rd_data", rd_data, 0);
        check("R8 mid reset pending", {31'd0, pending}, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule